// File: doc/BRIEF.md
# Flash Status Flag Generator

This block produces the status byte that a parallel NOR-style flash returns on a read while an embedded program or erase is running. The operating mode is an input: idle, program, erase, erase-suspend-read or erase-suspend-program. Each read strobe carries a sector number. The block keeps its own set of sectors chosen for erase, and it runs the timer for the window in which further sector erase commands are still taken. It also watches the active time of the operation against a limit. It returns two toggle bits with different toggling rules, an over-time flag and an erase-window flag. When no status applies, it returns the array data that is presented on its input.

Every read is captured on the rising edge of the read strobe. The byte for that read appears on the output one clock later and holds until the next read. Software reads twice and compares. If a toggle bit changes between the two reads, the operation is still running.

Top module: `flash_status_gen`

## Requirements
- R1: In idle mode (encoding 0) and in the unused mode codes 5 to 7, a read returns the array data input, sampled at the read edge, and no status bits are driven.
- R2: In program (1), erase (2) and suspend-program (4) modes, each read inverts bit 6, so two reads in a row return opposite values of bit 6. The status byte holds bit 6, bit 5, bit 3 and bit 2, and every other bit is 0.
- R3: In suspend-read mode (3), bit 6 does not change, and each read from a sector in the erase set inverts bit 2.
- R4: In erase mode, a read from a sector in the erase set inverts bit 2. A read from any other sector leaves bit 2 as it was.
- R5: A read in program mode, or a read in suspend-program mode from a sector outside the erase set, returns bit 2 as 1.
- R6: In suspend-read mode, a read from a sector outside the erase set returns array data.
- R7: After the first sector erase command, bit 3 reads 0 for WINDOW_CYCLES clocks. It then reads 1 while the erase set is non-empty.
- R8: A sector erase command given in erase mode while the window is open adds its sector to the erase set and restarts the full window.
- R9: A sector erase command given while bit 3 is 1 is ignored, and its sector does not join the erase set.
- R10: Bit 5 becomes 1 after OP_LIMIT clocks in program, erase or suspend-program mode. It stays 1 through any mode change and is cleared only by the reset command. Suspend-read time does not count toward the limit.
- R11: Toggle bits and the output change only at a rising edge of the read strobe. Holding the strobe high causes no further change.
- R12: After reset the output is 0. The erase set is cleared whenever the mode is idle or program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operation mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_i | input | 1 | Read strobe, a read is taken on its rising edge |
| rd_sector_i | input | SEC_W | Sector addressed by the read |
| erase_cmd_i | input | 1 | One-cycle sector erase command |
| erase_sector_i | input | SEC_W | Sector named by the erase command |
| reset_cmd_i | input | 1 | Reset command, clears the over-time flag |
| array_data_i | input | DATA_W | Array data returned when no status applies |
| dout_o | output | DATA_W | Byte returned by the most recent read |

## Verification
The bench builds the block with eight sectors, an erase window of 8 clocks and a time limit of 40 clocks. With a window this short, one test can take a second erase command while the window is still open and then show that the window restarted. Without the restart, the window would already have closed at that point. The bench also reaches the closed-window case in a few clocks and shows that a late command is ignored. With the limit this short, the over-time flag is set and its persistence is checked after a detour through idle mode, and the reset command that clears it is exercised as well.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        M_IDLE    = 3'd0,
        M_PROG    = 3'd1,
        M_ERASE   = 3'd2,
        M_SUSP_RD = 3'd3,
        M_SUSP_PG = 3'd4
    } op_mode_e;

    localparam int BIT_TOG_A = 6;
    localparam int BIT_TMO   = 5;
    localparam int BIT_WIN   = 3;
    localparam int BIT_TOG_B = 2;

    // modes in which an embedded algorithm is actively running
    function automatic logic mode_running(input logic [2:0] m);
        return (m == M_PROG) || (m == M_ERASE) || (m == M_SUSP_PG);
    endfunction

    // modes in which the erase set is retained
    function automatic logic mode_erase_ctx(input logic [2:0] m);
        return (m == M_ERASE) || (m == M_SUSP_RD) || (m == M_SUSP_PG);
    endfunction

    // any non-idle legal mode
    function automatic logic mode_legal_busy(input logic [2:0] m);
        return (m >= M_PROG) && (m <= M_SUSP_PG);
    endfunction

endpackage

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic q_o
);
    typedef struct packed {
        logic bit_v;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flip_i) st_d.bit_v = ~st_q.bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bit_v;
endmodule

// File: rtl/fsg_window.sv
module fsg_window #(
    parameter int NUM_SECTORS   = 8,
    parameter int WINDOW_CYCLES = 64,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_i,
    input  logic                   cmd_i,
    input  logic [SEC_W-1:0]       cmd_sector_i,
    output logic [NUM_SECTORS-1:0] set_o,
    output logic                   closed_o
);
    import fsg_pkg::*;

    typedef struct packed {
        logic [NUM_SECTORS-1:0] set;
        logic [CNT_W-1:0]       cnt;
    } win_t;

    win_t st_d, st_q;
    logic [NUM_SECTORS-1:0] hit;
    logic                   accept;
    logic                   closed;

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_hit
        assign hit[g] = (cmd_sector_i == SEC_W'(g));
    end

    always_comb begin
        closed = (st_q.set != '0) && (st_q.cnt == '0);
        accept = cmd_i && (mode_i == M_ERASE) && !closed;
        st_d   = st_q;
        if (!mode_erase_ctx(mode_i)) begin
            st_d.set = '0;
            st_d.cnt = '0;
        end else if (accept) begin
            st_d.set = st_q.set | hit;
            st_d.cnt = CNT_W'(WINDOW_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign set_o    = st_q.set;
    assign closed_o = closed;
endmodule

// File: rtl/fsg_timeout.sv
module fsg_timeout #(
    parameter int OP_LIMIT = 1000,
    localparam int TC_W = $clog2(OP_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       clr_i,
    output logic       flag_o
);
    import fsg_pkg::*;

    typedef struct packed {
        logic [TC_W-1:0] cnt;
        logic            flag;
    } tmo_t;

    tmo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (!mode_legal_busy(mode_i)) begin
            st_d.cnt = '0;
        end else if (mode_running(mode_i) && !st_q.flag) begin
            if (st_q.cnt == TC_W'(OP_LIMIT - 1)) st_d.flag = 1'b1;
            else                                 st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int NUM_SECTORS   = 8,
    parameter int WINDOW_CYCLES = 64,
    parameter int OP_LIMIT      = 1000,
    parameter int DATA_W        = 8,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              rd_i,
    input  logic [SEC_W-1:0]  rd_sector_i,
    input  logic              erase_cmd_i,
    input  logic [SEC_W-1:0]  erase_sector_i,
    input  logic              reset_cmd_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] dout_o
);
    import fsg_pkg::*;

    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] dout;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_SECTORS-1:0] erase_set;
    logic                   win_closed;
    logic                   tmo_flag;
    logic                   tog_a, tog_b;
    logic                   rd_rise, in_set;
    logic                   flip_a, flip_b;
    logic                   tog_a_nxt, tog_b_nxt;
    logic                   dq2, show_status;
    logic [DATA_W-1:0]      status;

    fsg_window #(.NUM_SECTORS(NUM_SECTORS), .WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cmd_i(erase_cmd_i), .cmd_sector_i(erase_sector_i),
        .set_o(erase_set), .closed_o(win_closed)
    );

    fsg_timeout #(.OP_LIMIT(OP_LIMIT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .clr_i(reset_cmd_i), .flag_o(tmo_flag)
    );

    fsg_toggle u_tog_a (.clk(clk), .rst_n(rst_n), .flip_i(flip_a), .q_o(tog_a));
    fsg_toggle u_tog_b (.clk(clk), .rst_n(rst_n), .flip_i(flip_b), .q_o(tog_b));

    always_comb begin
        rd_rise   = rd_i && !st_q.rd;
        in_set    = erase_set[rd_sector_i];
        flip_a    = rd_rise && mode_running(mode_i);
        flip_b    = rd_rise && in_set && mode_erase_ctx(mode_i);
        tog_a_nxt = tog_a ^ flip_a;
        tog_b_nxt = tog_b ^ flip_b;

        if ((mode_i == M_PROG) || ((mode_i == M_SUSP_PG) && !in_set)) dq2 = 1'b1;
        else                                                          dq2 = tog_b_nxt;

        show_status = mode_running(mode_i) || ((mode_i == M_SUSP_RD) && in_set);

        status            = '0;
        status[BIT_TOG_A] = tog_a_nxt;
        status[BIT_TMO]   = tmo_flag;
        status[BIT_WIN]   = win_closed;
        status[BIT_TOG_B] = dq2;

        st_d    = st_q;
        st_d.rd = rd_i;
        if (rd_rise) st_d.dout = show_status ? status : array_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o = st_q.dout;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int NUM_SECTORS = 8,
    parameter int SEC_W       = 3,
    parameter int DATA_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             mode_i,
    input logic                   rd_i,
    input logic [SEC_W-1:0]       rd_sector_i,
    input logic                   reset_cmd_i,
    input logic [DATA_W-1:0]      array_data_i,
    input logic [DATA_W-1:0]      dout_o,
    input logic [NUM_SECTORS-1:0] erase_set,
    input logic                   win_closed,
    input logic                   tmo_flag,
    input logic                   tog_a
);
    logic rd_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_i;
    end

    a_r11_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prev || !rd_i) |=> $stable(dout_o));

    a_r1_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && rd_i && !rd_prev) |=> (dout_o == $past(array_data_i)));

    a_r2_dq6_flips: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'd1 || mode_i == 3'd2 || mode_i == 3'd4) && rd_i && !rd_prev)
        |=> (tog_a != $past(tog_a)));

    a_r3_dq6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd3) |=> $stable(tog_a));

    a_r5_dq2_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd4 && rd_i && !rd_prev && !erase_set[rd_sector_i]) |=> dout_o[2]);

    a_r9_closed_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (win_closed && mode_i == 3'd2) |=> $stable(erase_set));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !reset_cmd_i) |=> tmo_flag);

    a_r12_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 || mode_i == 3'd1) |=> (erase_set == '0));
endmodule

bind flash_status_gen fsg_checker #(
    .NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_i(rd_i),
    .rd_sector_i(rd_sector_i), .reset_cmd_i(reset_cmd_i),
    .array_data_i(array_data_i), .dout_o(dout_o),
    .erase_set(erase_set), .win_closed(win_closed),
    .tmo_flag(tmo_flag), .tog_a(tog_a)
);

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
    localparam int NS  = 8;
    localparam int WIN = 8;
    localparam int LIM = 40;
    localparam int SW  = 3;
    localparam logic [2:0] IDLE = 3'd0, PROG = 3'd1, ERASE = 3'd2, SRD = 3'd3, SPG = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] mode = IDLE;
    logic rd = 1'b0, ecmd = 1'b0, rcmd = 1'b0;
    logic [SW-1:0] rsec = '0, esec = '0;
    logic [7:0] adata = 8'h00;
    logic [7:0] dout;

    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_status_gen #(.NUM_SECTORS(NS), .WINDOW_CYCLES(WIN), .OP_LIMIT(LIM), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_i(rd), .rd_sector_i(rsec),
        .erase_cmd_i(ecmd), .erase_sector_i(esec), .reset_cmd_i(rcmd),
        .array_data_i(adata), .dout_o(dout)
    );

    // behavioural reference model
    bit m_rdp, m_t6, m_t2, m_d5;
    bit [NS-1:0] m_set;
    int m_wc, m_tc;
    logic [7:0] m_out;

    function automatic bit is_running(logic [2:0] m);
        return m == PROG || m == ERASE || m == SPG;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rdp = 0; m_t6 = 0; m_t2 = 0; m_d5 = 0; m_set = '0; m_wc = 0; m_tc = 0; m_out = 8'h00;
        end else begin
            bit rise, ins, closed, b2;
            rise   = rd && !m_rdp;
            ins    = m_set[rsec];
            closed = (m_set != 0) && (m_wc == 0);
            if (rise) begin
                if (is_running(mode)) m_t6 = !m_t6;
                if (ins && (mode == ERASE || mode == SRD || mode == SPG)) m_t2 = !m_t2;
                b2 = (mode == PROG || (mode == SPG && !ins)) ? 1'b1 : m_t2;
                if (is_running(mode) || (mode == SRD && ins))
                    m_out = {1'b0, m_t6, m_d5, 1'b0, closed, b2, 2'b00};
                else
                    m_out = adata;
            end
            if (!(mode == ERASE || mode == SRD || mode == SPG)) begin
                m_set = '0; m_wc = 0;
            end else if (mode == ERASE && ecmd && !closed) begin
                m_set[esec] = 1'b1; m_wc = WIN;
            end else if (m_wc > 0) m_wc--;
            if (rcmd) begin m_tc = 0; m_d5 = 0; end
            else if (!(mode >= PROG && mode <= SPG)) m_tc = 0;
            else if (is_running(mode) && !m_d5) begin
                m_tc++;
                if (m_tc == LIM) m_d5 = 1;
            end
            m_rdp = rd;
        end
    end

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            PROG:    return "R2";
            ERASE:   return "R4";
            SRD:     return "R3";
            SPG:     return "R5";
            default: return "R1";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dout !== m_out) begin
                errors++;
                $display("FAIL %s/R11 per-cycle model: actual=%h expected=%h", mode_tag(mode), dout, m_out);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input int sec, output logic [7:0] v);
        @(negedge clk); rd = 1'b1; rsec = SW'(sec);
        @(negedge clk); v = dout; rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_erase(input int sec);
        @(negedge clk); ecmd = 1'b1; esec = SW'(sec);
        @(negedge clk); ecmd = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk); mode = m;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] a, b, c;
        repeat (3) @(negedge clk);
        chk("R12 reset output", dout, 8'h00);
        rst_n = 1'b1;

        // R1: idle and unused codes return array data
        adata = 8'hA5;
        do_read(3, a); chk("R1 idle read", a, 8'hA5);
        set_mode(3'd6); adata = 8'h5A;
        do_read(0, a); chk("R1 unused mode read", a, 8'h5A);
        set_mode(IDLE);

        // R2 / R5: program mode
        set_mode(PROG);
        do_read(1, a); do_read(1, b);
        chk("R2 bit6 opposite", {7'd0, a[6] ^ b[6]}, 8'd1);
        chk("R2 other bits zero", b & 8'h93, 8'h00);
        chk("R5 program bit2 high", {7'd0, b[2]}, 8'd1);

        // R11: strobe held high, no retoggle
        @(negedge clk); rd = 1'b1;
        @(negedge clk); a = dout;
        repeat (4) @(negedge clk);
        chk("R11 held strobe stable", dout, a);
        rd = 1'b0;
        do_read(1, b);
        chk("R11 next edge flips once", {7'd0, a[6] ^ b[6]}, 8'd1);
        set_mode(IDLE);

        // R7 / R8 / R9 / R4: erase window
        set_mode(ERASE);
        do_erase(2);
        do_read(2, a); chk("R7 window open bit3", {7'd0, a[3]}, 8'd0);
        repeat (2) @(negedge clk);
        do_erase(5);
        do_read(5, a); do_read(5, b);
        chk("R8 added sector toggles bit2", {7'd0, a[2] ^ b[2]}, 8'd1);
        chk("R8 window restarted bit3", {7'd0, b[3]}, 8'd0);
        repeat (12) @(negedge clk);
        do_read(2, a); chk("R7 window closed bit3", {7'd0, a[3]}, 8'd1);
        do_erase(6);
        do_read(6, a); do_read(6, b);
        chk("R9 late sector bit2 holds", {7'd0, a[2] ^ b[2]}, 8'd0);
        do_read(2, a); do_read(2, b);
        chk("R4 erasing sector bit2 flips", {7'd0, a[2] ^ b[2]}, 8'd1);
        do_read(1, a); do_read(1, b);
        chk("R4 other sector bit2 holds", {7'd0, a[2] ^ b[2]}, 8'd0);

        // R3 / R6: suspend-read
        set_mode(SRD);
        do_read(2, a); do_read(2, b);
        chk("R3 bit2 flips in suspend-read", {7'd0, a[2] ^ b[2]}, 8'd1);
        chk("R3 bit6 frozen", {7'd0, a[6] ^ b[6]}, 8'd0);
        adata = 8'h3C;
        do_read(0, a); chk("R6 outside set returns data", a, 8'h3C);

        // R5: suspend-program outside set
        set_mode(SPG);
        do_read(0, a); do_read(0, b);
        chk("R5 suspend-program bit2 high", {7'd0, b[2]}, 8'd1);
        chk("R2 suspend-program bit6 flips", {7'd0, a[6] ^ b[6]}, 8'd1);

        // R10: over-time flag
        set_mode(ERASE);
        repeat (LIM + 10) @(negedge clk);
        do_read(1, a); chk("R10 flag set", {7'd0, a[5]}, 8'd1);
        set_mode(IDLE); adata = 8'h11;
        do_read(1, a); chk("R1 idle after timeout", a, 8'h11);
        set_mode(ERASE);
        do_read(1, a); chk("R10 flag sticky", {7'd0, a[5]}, 8'd1);
        chk("R12 set cleared by idle", {7'd0, a[3]}, 8'd0);
        @(negedge clk); rcmd = 1'b1;
        @(negedge clk); rcmd = 1'b0;
        do_read(1, c); chk("R10 reset command clears", {7'd0, c[5]}, 8'd0);
        set_mode(IDLE);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule